// File: doc/BRIEF.md
# Mode-Selected Coefficient Memory Loader

This block fills two on-chip coefficient memories through one narrow beat bus. One memory holds a search tree of 12-bit node words. The other holds 60-bit parameter words, each made of five 12-bit coefficients. A 2-bit mode input picks the target memory. The block drives only the write port of each memory: address, data and a one-cycle write strobe. The memories and the logic that reads them are outside this block.

A tree word takes two beats: an address beat, then a data beat. A parameter word takes six beats: an address beat, then five coefficient beats. Beats use a valid/ready handshake, and a beat is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` depends only on the mode and never on the state of a sequence. It is high in both write modes, so a held `in_valid` streams one beat per cycle. It is low in the run and test modes, which is the only case where the block pushes back. The source may leave gaps between beats, and the block waits through them. A change of mode in the middle of a sequence discards that sequence without writing anything.

Top module: `ldr_top`

## Requirements
- R1: After reset both write strobes are low and every address and data output is zero.
- R2: The modes are encoded as 2'b00 run, 2'b01 tree write, 2'b10 parameter write and 2'b11 test. `in_ready` is high exactly in the modes 2'b01 and 2'b10.
- R3: In tree mode the first accepted beat gives the address (`in_data[13:0]`) and the second gives the data (`in_data[11:0]`). `tree_we` is high for the one cycle after the edge that takes the data beat, with `tree_addr` and `tree_wdata` holding those values.
- R4: In parameter mode the first accepted beat gives the address (`in_data[11:0]`). It is followed by five coefficient beats, taken from `in_data[11:0]`. Coefficient beat j (j = 0..4) lands in `par_wdata[12j+11:12j]`. `par_we` is high for the one cycle after the edge that takes the fifth coefficient beat.
- R5: Each write strobe is a single-cycle pulse, and the two strobes are never high in the same cycle.
- R6: With `in_valid` held high, the block writes one tree word every 2 cycles in tree mode and one parameter word every 6 cycles in parameter mode.
- R7: Cycles with `in_valid` low between beats neither lose a beat nor add one.
- R8: A change of mode in the middle of a sequence aborts that sequence and writes nothing for it. A beat accepted in the cycle the new mode first appears is the address beat of a new sequence.
- R9: In the run and test modes, beats are not accepted and nothing is written. A stray beat offered in these modes is not counted toward the next write sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Operating mode (see R2) |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be taken (write modes only) |
| in_data | input | 14 | Beat payload |
| tree_we | output | 1 | Tree memory write strobe |
| tree_addr | output | 14 | Tree memory write address |
| tree_wdata | output | 12 | Tree memory write data |
| par_we | output | 1 | Parameter memory write strobe |
| par_addr | output | 12 | Parameter memory write address |
| par_wdata | output | 60 | Parameter memory write data |

## Verification
The hardest case to reach is a mode switch that lands partway through a sequence. Whatever the block had counted must then be dropped, and the beat arriving in that same cycle must be taken as a fresh address. The stimulus reaches this on purpose. It starts tree and parameter sequences, switches the mode after a chosen number of beats, and then sends a complete word in the new mode. Only that final word may appear at the write ports, with exactly its own fields. Long random runs with random gaps between beats then exercise field placement and the pacing of the strobes.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_TREE  = 2'b01,
    MODE_PARAM = 2'b10,
    MODE_TEST  = 2'b11
  } ldr_mode_e;
endpackage

// File: rtl/ldr_seq.sv
module ldr_seq #(
  parameter int NFIELD = 5,
  parameter int CW     = $clog2(NFIELD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          fire,
  output logic [CW-1:0] idx,
  output logic          last
);
  import ldr_pkg::*;

  localparam logic [CW-1:0] TREE_LAST  = CW'(1);
  localparam logic [CW-1:0] PARAM_LAST = CW'(NFIELD);

  logic [1:0]    mode_q;
  logic [CW-1:0] cnt;
  logic          mode_chg;
  logic [CW-1:0] last_idx;

  assign mode_chg = (mode != mode_q);
  // A fresh mode always starts with the address beat
  assign idx      = mode_chg ? '0 : cnt;
  assign last_idx = (mode == MODE_TREE) ? TREE_LAST : PARAM_LAST;
  assign last     = fire && (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      cnt    <= '0;
    end else begin
      mode_q <= mode;
      if (fire)          cnt <= last ? '0 : idx + CW'(1);
      else if (mode_chg) cnt <= '0;
    end
  end

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PARAM_LAST);
  // R8: after a mode switch only the switch-cycle beat can have been counted
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != mode_q) |=> (cnt <= CW'(1)));
endmodule

// File: rtl/ldr_pack.sv
module ldr_pack #(
  parameter int BUS_W  = 14,
  parameter int AW     = 14,
  parameter int FW     = 12,
  parameter int NFIELD = 5,
  parameter int CW     = $clog2(NFIELD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [CW-1:0]        idx,
  input  logic [BUS_W-1:0]     din,
  output logic [AW-1:0]        addr_q,
  output logic [NFIELD*FW-1:0] fields_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  addr_q <= '0;
    else if (fire && idx == '0)  addr_q <= din[AW-1:0];
  end

  for (genvar j = 0; j < NFIELD; j++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         fields_q[j*FW +: FW] <= '0;
      else if (fire && idx == CW'(j + 1)) fields_q[j*FW +: FW] <= din[FW-1:0];
    end
  end
endmodule

// File: rtl/ldr_top.sv
module ldr_top #(
  parameter int TREE_AW = 14,
  parameter int PAR_AW  = 12,
  parameter int FW      = 12,
  parameter int NFIELD  = 5,
  parameter int AW      = (TREE_AW > PAR_AW) ? TREE_AW : PAR_AW,
  parameter int BUS_W   = (AW > FW) ? AW : FW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BUS_W-1:0]     in_data,
  output logic                 tree_we,
  output logic [TREE_AW-1:0]   tree_addr,
  output logic [FW-1:0]        tree_wdata,
  output logic                 par_we,
  output logic [PAR_AW-1:0]    par_addr,
  output logic [NFIELD*FW-1:0] par_wdata
);
  import ldr_pkg::*;

  localparam int CW = $clog2(NFIELD + 1);

  logic          fire;
  logic          last;
  logic [CW-1:0] idx;
  logic [AW-1:0] addr_q;
  logic [NFIELD*FW-1:0] fields_q;

  assign in_ready = (mode == MODE_TREE) || (mode == MODE_PARAM);
  assign fire     = in_valid && in_ready;

  ldr_seq #(.NFIELD(NFIELD), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fire(fire), .idx(idx), .last(last)
  );

  ldr_pack #(.BUS_W(BUS_W), .AW(AW), .FW(FW), .NFIELD(NFIELD), .CW(CW)) u_pack (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idx(idx), .din(in_data),
    .addr_q(addr_q), .fields_q(fields_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tree_we <= 1'b0;
      par_we  <= 1'b0;
    end else begin
      tree_we <= last && (mode == MODE_TREE);
      par_we  <= last && (mode == MODE_PARAM);
    end
  end

  assign tree_addr  = addr_q[TREE_AW-1:0];
  assign tree_wdata = fields_q[FW-1:0];
  assign par_addr   = addr_q[PAR_AW-1:0];
  assign par_wdata  = fields_q;

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(tree_we && par_we));
  a_r5_tree_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tree_we |=> !tree_we);
  a_r5_par_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    par_we |=> !par_we);
  a_r3_tree_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    tree_we |-> ($past(in_valid) && $past(mode) == MODE_TREE));
  a_r4_par_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    par_we |-> ($past(in_valid) && $past(mode) == MODE_PARAM));
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_RUN || $past(mode) == MODE_TEST) |-> !(tree_we || par_we));
endmodule

// File: tb/sim_ldr_top.sv
module sim_ldr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_data = '0;
  logic        tree_we, par_we;
  logic [13:0] tree_addr;
  logic [11:0] tree_wdata;
  logic [11:0] par_addr;
  logic [59:0] par_wdata;

  always #2.5 clk = ~clk;

  ldr_top u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tree_we(tree_we), .tree_addr(tree_addr), .tree_wdata(tree_wdata),
    .par_we(par_we), .par_addr(par_addr), .par_wdata(par_wdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int pulse_err = 0;
  int last_we_cyc = -1;
  bit thru = 0;
  bit prev_tw = 0, prev_pw = 0;
  logic [25:0] exp_t[$], got_t[$];
  logic [71:0] exp_p[$], got_p[$];
  int gap_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((tree_we && prev_tw) || (par_we && prev_pw) || (tree_we && par_we))
        pulse_err++;
      if (tree_we) got_t.push_back({tree_addr, tree_wdata});
      if (par_we)  got_p.push_back({par_addr, par_wdata});
      if (tree_we || par_we) begin
        if (thru && last_we_cyc >= 0) gap_q.push_back(cyc - last_we_cyc);
        last_we_cyc = cyc;
      end
      prev_tw = tree_we;
      prev_pw = par_we;
    end
  end

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [59:0] pack5(input logic [11:0] f[5]);
    logic [59:0] r = '0;
    for (int j = 0; j < 5; j++) r[12*j +: 12] = f[j];
    return r;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic put(input logic [13:0] d);
    in_valid = 1'b1; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic tree_word(input logic [13:0] a, input logic [11:0] d, input int gap);
    put(a); idle(gap); put({2'b00, d}); idle(gap);
    exp_t.push_back({a, d});
  endtask

  task automatic par_word(input logic [11:0] a, input logic [11:0] f[5], input int gap);
    put({2'b00, a}); idle(gap);
    for (int j = 0; j < 5; j++) begin put({2'b00, f[j]}); idle(gap); end
    exp_p.push_back({a, pack5(f)});
  endtask

  task automatic compare(input string req);
    idle(3);
    check(got_t.size() == exp_t.size(), {req, " tree write count"}, 96'(got_t.size()), 96'(exp_t.size()));
    for (int i = 0; i < exp_t.size() && i < got_t.size(); i++)
      check(got_t[i] == exp_t[i], {req, " tree word"}, 96'(got_t[i]), 96'(exp_t[i]));
    check(got_p.size() == exp_p.size(), {req, " param write count"}, 96'(got_p.size()), 96'(exp_p.size()));
    for (int i = 0; i < exp_p.size() && i < got_p.size(); i++)
      check(got_p[i] == exp_p[i], {req, " param word"}, 96'(got_p[i]), 96'(exp_p[i]));
    exp_t.delete(); got_t.delete(); exp_p.delete(); got_p.delete();
  endtask

  task automatic finish_run();
    check(pulse_err == 0, "R5 single-cycle exclusive strobes", 96'(pulse_err), 96'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] f[5];
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!tree_we && !par_we, "R1 strobes low", 96'({tree_we, par_we}), 96'(0));
    check(tree_addr == 0 && tree_wdata == 0 && par_addr == 0 && par_wdata == 0,
          "R1 outputs zero", 96'(par_wdata), 96'(0));
    // R2 ready per mode
    for (int m = 0; m < 4; m++) begin
      @(posedge clk); #1; mode = 2'(m); #1;
      check(in_ready == (m == 1 || m == 2), "R2 ready per mode", 96'(in_ready), 96'(m == 1 || m == 2));
    end
    idle(1);
    // R3 directed tree, extreme values
    mode = 2'b01; idle(1);
    tree_word(14'h3FFF, 12'hFFF, 0);
    tree_word(14'h0000, 12'h000, 0);
    tree_word(14'h2A55, 12'hA5C, 2);
    compare("R3");
    // R4 directed param with distinct fields
    mode = 2'b10; idle(1);
    f = '{12'h111, 12'h222, 12'h333, 12'h444, 12'h555};
    par_word(12'hFFF, f, 0);
    f = '{12'hFFF, 12'h000, 12'hFFF, 12'h000, 12'hABC};
    par_word(12'h001, f, 1);
    compare("R4");
    // R6 throughput with valid held
    mode = 2'b01; idle(1);
    thru = 1; last_we_cyc = -1;
    for (int i = 0; i < 6; i++) tree_word(14'($urandom), 12'($urandom), 0);
    idle(3); thru = 0;
    check(gap_q.size() == 5, "R6 tree gap count", 96'(gap_q.size()), 96'(5));
    foreach (gap_q[i]) check(gap_q[i] == 2, "R6 tree spacing", 96'(gap_q[i]), 96'(2));
    gap_q.delete();
    compare("R6");
    mode = 2'b10; idle(1);
    thru = 1; last_we_cyc = -1;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 5; j++) f[j] = 12'($urandom);
      par_word(12'($urandom), f, 0);
    end
    idle(3); thru = 0;
    check(gap_q.size() == 3, "R6 param gap count", 96'(gap_q.size()), 96'(3));
    foreach (gap_q[i]) check(gap_q[i] == 6, "R6 param spacing", 96'(gap_q[i]), 96'(6));
    gap_q.delete();
    compare("R6");
    // R8 abort tree after address, switch straight to param with a beat in switch cycle
    mode = 2'b01; idle(1);
    put(14'h1234);
    mode = 2'b10;
    f = '{12'h0A1, 12'h0B2, 12'h0C3, 12'h0D4, 12'h0E5};
    par_word(12'h777, f, 0);
    compare("R8");
    // R8 abort param after three coefficients, then tree word
    mode = 2'b10; idle(1);
    put(14'h0055); put(14'h0001); put(14'h0002); put(14'h0003);
    mode = 2'b01;
    tree_word(14'h0ABC, 12'h321, 0);
    compare("R8");
    // R9 stray beats in run and test modes, abort via run mode
    mode = 2'b10; idle(1);
    put(14'h0066); put(14'h0099);
    mode = 2'b00; idle(1);
    in_valid = 1'b1; in_data = 14'h0FFF; #1;
    check(!in_ready, "R9 ready low in run", 96'(in_ready), 96'(0));
    idle(3);
    mode = 2'b11; idle(3);
    check(!in_ready, "R9 ready low in test", 96'(in_ready), 96'(0));
    in_valid = 1'b0;
    mode = 2'b10;
    f = '{12'h101, 12'h202, 12'h303, 12'h404, 12'h505};
    par_word(12'h0EE, f, 0);
    compare("R9");
    // R7 random gaps, mixed modes
    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(1, 0) == 0) begin
        mode = 2'b01; idle(1);
        tree_word(14'($urandom), 12'($urandom), $urandom_range(3, 0));
      end else begin
        mode = 2'b10; idle(1);
        for (int j = 0; j < 5; j++) f[j] = 12'($urandom);
        par_word(12'($urandom), f, $urandom_range(3, 0));
      end
    end
    compare("R7");
    finish_run();
  end
endmodule